// File: doc/BRIEF.md
# Control-Port Enable and Bus-Format Supervisor

This block decides whether a device takes its configuration from strapped pins or from a serial control port. After reset it times a stand-alone power-up phase by counting frame-clock edges. When software writes the enable bit of the control port, the block aborts that timer if it is still running. It also issues a one-cycle pulse that loads every control register with its default value, and it hands the shared pins to the serial port. This hand-off is one-way: only reset undoes it.

Once the port is active, the block watches the shared chip-select/address pin. The first falling edge it sees from then on selects SPI, and that choice holds until reset. If no falling edge arrives, the port stays in I2C format, and the pin keeps its role as an address bit. Both the frame clock and the shared pin are asynchronous, so each passes through a synchronizer and an edge detector in the system clock domain. A flag records whether the enable came after the stand-alone phase had already finished, because such a late switch may be audible.

Top module: `cp_supervisor`

## Requirements
- R1: While reset is low and just after it is released, port_active, i2c_sel, spi_sel, dflt_load, pwrup_done and late_en are all 0.
- R2: pwrup_done goes to 1 on the PWRUP_FRAMES-th counted frame-clock edge (rising by default), SYNC_STAGES+1 clock edges after that frame-clock edge, and it then stays 1 until reset.
- R3: A cpen_wr pulse while the port is inactive sets port_active and i2c_sel at the next clock edge.
- R4: dflt_load is high for exactly one cycle, the first cycle in which port_active is 1.
- R5: If the enable arrives before pwrup_done, the timer stops and pwrup_done stays 0 however many frame-clock edges follow.
- R6: The enable is accepted both before and after pwrup_done. late_en is set together with port_active and equals the value pwrup_done had when the enable was taken.
- R7: cpen_wr pulses while the port is already active have no effect: there is no new dflt_load, and the mode and late_en do not change.
- R8: A falling edge on cs_pin while the port is active sets spi_sel to 1 and i2c_sel to 0, SYNC_STAGES+1 clock edges after the pin falls.
- R9: Falling edges on cs_pin before the port is active, and rising edges at any time, do not select SPI.
- R10: spi_sel stays 1 under any later cs_pin or cpen_wr activity, until reset.
- R11: port_active stays 1 until reset, and spi_sel and i2c_sel are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| lrck | input | 1 | Frame clock, asynchronous |
| cpen_wr | input | 1 | One-cycle strobe: control-port enable bit written |
| cs_pin | input | 1 | Shared chip-select/address pin, asynchronous |
| port_active | output | 1 | Control port owns the shared pins |
| i2c_sel | output | 1 | Port active in I2C format |
| spi_sel | output | 1 | Port active in SPI format |
| dflt_load | output | 1 | One-cycle pulse: load control registers with defaults |
| pwrup_done | output | 1 | Stand-alone power-up timer has expired |
| late_en | output | 1 | Enable arrived after the stand-alone phase ended |

## Verification
The enable path has a latency of one clock edge: port_active, i2c_sel, dflt_load and late_en all change at the first edge after the strobe. The bench therefore drives cpen_wr on a falling clock edge and samples one falling edge later. Both pin paths pass through SYNC_STAGES synchronizer flops and then one state register. pwrup_done and spi_sel therefore move SYNC_STAGES+1 edges after the pin changes. The bench checks that the output is still unchanged after SYNC_STAGES edges and has changed after one more. Checks that only concern settled state wait several extra cycles before sampling.

// File: rtl/cp_supervisor_pkg.sv
package cp_supervisor_pkg;
   typedef enum logic [1:0] {
      MODE_STRAP = 2'd0,
      MODE_I2C   = 2'd1,
      MODE_SPI   = 2'd2
   } port_mode_e;
endpackage

// File: rtl/cp_edge_sync.sv
module cp_edge_sync #(
   parameter int STAGES    = 2,
   parameter bit WANT_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic edge_pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cp_edge_sync: STAGES must be at least 2");
   end

   logic sh [STAGES];
   logic prev;
   logic [STAGES:0] fill;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[g] <= 1'b0;
            else        sh[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[g] <= 1'b0;
            else        sh[g] <= sh[g-1];
         end
      end
   end

   // history register and arming shift: edges count only once real samples fill the chain
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b0;
         fill <= '0;
      end else begin
         prev <= sh[STAGES-1];
         fill <= {fill[STAGES-1:0], 1'b1};
      end
   end

   if (WANT_RISE) begin : g_rise
      assign edge_pulse = fill[STAGES] & sh[STAGES-1] & ~prev;
   end else begin : g_fall
      assign edge_pulse = fill[STAGES] & ~sh[STAGES-1] & prev;
   end
endmodule

// File: rtl/cp_pwrup_timer.sv
module cp_pwrup_timer #(
   parameter int FRAMES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_tick,
   input  logic halt,
   output logic done
);
   if (FRAMES < 1) begin : g_bad_frames
      $error("cp_pwrup_timer: FRAMES must be at least 1");
   end

   localparam int CW = $clog2(FRAMES + 1);
   localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!done && !halt && frame_tick) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST) done <= 1'b1;
      end
   end
endmodule

// File: rtl/cp_mode_ctl.sv
module cp_mode_ctl
   import cp_supervisor_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpen_wr,
   input  logic       cs_fall,
   input  logic       pwrup_done,
   output port_mode_e mode,
   output logic       dflt_load,
   output logic       late_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= MODE_STRAP;
         dflt_load <= 1'b0;
         late_en   <= 1'b0;
      end else begin
         dflt_load <= 1'b0;
         unique case (mode)
            MODE_STRAP: if (cpen_wr) begin
               mode      <= MODE_I2C;
               dflt_load <= 1'b1;
               late_en   <= pwrup_done;
            end
            MODE_I2C: if (cs_fall) mode <= MODE_SPI;
            MODE_SPI: mode <= MODE_SPI;
            default:  mode <= MODE_STRAP;
         endcase
      end
   end
endmodule

// File: rtl/cp_supervisor.sv
module cp_supervisor
   import cp_supervisor_pkg::*;
#(
   parameter int PWRUP_FRAMES = 1024,
   parameter int SYNC_STAGES  = 2,
   parameter bit LRCK_RISE    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lrck,
   input  logic cpen_wr,
   input  logic cs_pin,
   output logic port_active,
   output logic i2c_sel,
   output logic spi_sel,
   output logic dflt_load,
   output logic pwrup_done,
   output logic late_en
);
   logic       frame_tick;
   logic       cs_fall;
   port_mode_e mode;

   cp_edge_sync #(.STAGES(SYNC_STAGES), .WANT_RISE(LRCK_RISE)) i_lrck_sync (
      .clk(clk), .rst_n(rst_n), .din(lrck), .edge_pulse(frame_tick)
   );

   cp_edge_sync #(.STAGES(SYNC_STAGES), .WANT_RISE(1'b0)) i_cs_sync (
      .clk(clk), .rst_n(rst_n), .din(cs_pin), .edge_pulse(cs_fall)
   );

   cp_pwrup_timer #(.FRAMES(PWRUP_FRAMES)) i_timer (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .halt(port_active), .done(pwrup_done)
   );

   cp_mode_ctl i_mode (
      .clk(clk), .rst_n(rst_n), .cpen_wr(cpen_wr), .cs_fall(cs_fall),
      .pwrup_done(pwrup_done), .mode(mode), .dflt_load(dflt_load),
      .late_en(late_en)
   );

   assign port_active = (mode != MODE_STRAP);
   assign i2c_sel     = (mode == MODE_I2C);
   assign spi_sel     = (mode == MODE_SPI);
endmodule

// File: rtl/cp_supervisor_chk.sv
module cp_supervisor_chk (
   input logic clk,
   input logic rst_n,
   input logic cpen_wr,
   input logic port_active,
   input logic i2c_sel,
   input logic spi_sel,
   input logic dflt_load,
   input logic pwrup_done,
   input logic late_en
);
   // R4
   dflt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dflt_load |=> !dflt_load);
   // R4
   dflt_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_active && !$past(port_active)) |-> dflt_load);
   // R4
   dflt_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dflt_load |-> port_active);
   // R11
   active_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_active |=> port_active);
   // R10
   spi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sel |=> spi_sel);
   // R11
   mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({spi_sel, i2c_sel}));
   // R9
   spi_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sel |-> port_active);
   // R2
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwrup_done |=> pwrup_done);
   // R5
   timer_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_active && !pwrup_done) |=> !pwrup_done);
   // R6
   late_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_active |=> $stable(late_en));
   // R3
   enable_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpen_wr && !port_active) |=> (port_active && i2c_sel));
endmodule

bind cp_supervisor cp_supervisor_chk i_cp_supervisor_chk (
   .clk(clk), .rst_n(rst_n), .cpen_wr(cpen_wr), .port_active(port_active),
   .i2c_sel(i2c_sel), .spi_sel(spi_sel), .dflt_load(dflt_load),
   .pwrup_done(pwrup_done), .late_en(late_en)
);

// File: tb/test_cp_supervisor.sv
module test_cp_supervisor;
   localparam int CLK_PERIOD = 10;
   localparam int FRAMES     = 1024;
   localparam int SYNC       = 2;
   localparam int WATCHDOG   = 190000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lrck = 1'b0;
   logic cpen_wr = 1'b0;
   logic cs_pin = 1'b1;
   logic port_active, i2c_sel, spi_sel, dflt_load, pwrup_done, late_en;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cp_supervisor #(.PWRUP_FRAMES(FRAMES), .SYNC_STAGES(SYNC)) i_cp_supervisor (
      .clk(clk), .rst_n(rst_n), .lrck(lrck), .cpen_wr(cpen_wr), .cs_pin(cs_pin),
      .port_active(port_active), .i2c_sel(i2c_sel), .spi_sel(spi_sel),
      .dflt_load(dflt_load), .pwrup_done(pwrup_done), .late_en(late_en)
   );

   function automatic bit exp_done(int edges);
      return edges >= FRAMES;
   endfunction

   task automatic check(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic lrck_pulses(int n, int half);
      for (int i = 0; i < n; i++) begin
         lrck = 1'b1; tick(half);
         lrck = 1'b0; tick(half);
      end
   endtask

   task automatic strobe_enable();
      cpen_wr = 1'b1; tick(1);
      cpen_wr = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; lrck = 1'b0; cs_pin = 1'b1; cpen_wr = 1'b0;
      tick(4);
      check("R1", "port_active in reset", port_active, 1'b0);
      check("R1", "dflt_load in reset", dflt_load, 1'b0);
      rst_n = 1'b1;
      tick(SYNC + 3);
      check("R1", "port_active", port_active, 1'b0);
      check("R1", "i2c_sel", i2c_sel, 1'b0);
      check("R1", "spi_sel", spi_sel, 1'b0);
      check("R1", "pwrup_done", pwrup_done, 1'b0);
      check("R1", "late_en", late_en, 1'b0);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog (all R) actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int seed;
      seed = $urandom(32'h0C5E_ED01);

      // directed: timer expiry at exact latency, then late enable and SPI
      do_reset();
      lrck_pulses(FRAMES - 1, 3);
      tick(SYNC + 2);
      check("R2", "done before last frame", pwrup_done, 1'b0);
      lrck = 1'b1;
      tick(SYNC);
      check("R2", "done one edge early", pwrup_done, 1'b0);
      tick(1);
      check("R2", "done at latency", pwrup_done, 1'b1);
      tick(2); lrck = 1'b0; tick(3);
      lrck_pulses(5, 3);
      check("R2", "done sticky", pwrup_done, 1'b1);
      cpen_wr = 1'b1; tick(1); cpen_wr = 1'b0;
      check("R3", "port_active after enable", port_active, 1'b1);
      check("R3", "i2c_sel after enable", i2c_sel, 1'b1);
      check("R4", "dflt_load first cycle", dflt_load, 1'b1);
      check("R6", "late_en after late enable", late_en, 1'b1);
      tick(1);
      check("R4", "dflt_load second cycle", dflt_load, 1'b0);
      strobe_enable();
      check("R7", "no second dflt_load", dflt_load, 1'b0);
      check("R7", "i2c kept", i2c_sel, 1'b1);
      check("R7", "late_en kept", late_en, 1'b1);
      cs_pin = 1'b0;
      tick(SYNC);
      check("R8", "spi one edge early", spi_sel, 1'b0);
      tick(1);
      check("R8", "spi_sel at latency", spi_sel, 1'b1);
      check("R8", "i2c_sel cleared", i2c_sel, 1'b0);
      for (int k = 0; k < 4; k++) begin
         cs_pin = ~cs_pin; tick(4);
      end
      strobe_enable(); tick(2);
      check("R10", "spi sticky", spi_sel, 1'b1);
      check("R11", "active sticky", port_active, 1'b1);
      check("R11", "i2c off in spi", i2c_sel, 1'b0);

      // directed: early enable halts timer; pre-enable falls and rises ignored
      do_reset();
      for (int k = 0; k < 3; k++) begin
         cs_pin = 1'b0; tick(4); cs_pin = 1'b1; tick(4);
      end
      cs_pin = 1'b0; tick(4);
      lrck_pulses(5, 2);
      check("R9", "no spi before enable", spi_sel, 1'b0);
      strobe_enable();
      check("R6", "late_en for early enable", late_en, 1'b0);
      check("R9", "i2c after pre-enable falls", i2c_sel, 1'b1);
      lrck_pulses(FRAMES + 20, 2);
      check("R5", "timer halted", pwrup_done, 1'b0);
      cs_pin = 1'b1; tick(SYNC + 3);
      check("R9", "rise ignored", spi_sel, 1'b0);
      cs_pin = 1'b0; tick(SYNC + 1);
      check("R8", "spi after active fall", spi_sel, 1'b1);

      // random trials
      for (int t = 0; t < 5; t++) begin
         int n_before, half, n_falls;
         bit go_spi, e_done;
         n_before = $urandom_range(FRAMES + 40, FRAMES - 60);
         if (t == 0) n_before = $urandom_range(30, 0);
         half     = $urandom_range(4, 2);
         n_falls  = $urandom_range(3, 0);
         go_spi   = 1'($urandom_range(1, 0));
         e_done   = exp_done(n_before);
         do_reset();
         for (int k = 0; k < n_falls; k++) begin
            cs_pin = 1'b0; tick($urandom_range(6, 3));
            cs_pin = 1'b1; tick($urandom_range(6, 3));
         end
         lrck_pulses(n_before, half);
         tick(SYNC + 2);
         check("R2", "random done before enable", pwrup_done, e_done);
         check("R9", "random no early spi", spi_sel, 1'b0);
         strobe_enable();
         check("R3", "random active", port_active, 1'b1);
         check("R4", "random dflt", dflt_load, 1'b1);
         check("R6", "random late_en", late_en, e_done);
         lrck_pulses(40, half);
         check("R5", "random done after enable", pwrup_done, e_done);
         if (go_spi) begin
            cs_pin = 1'b0; tick(SYNC + 1);
            check("R8", "random spi", spi_sel, 1'b1);
            cs_pin = 1'b1; tick(5); cs_pin = 1'b0; tick(5);
            check("R10", "random spi sticky", spi_sel, 1'b1);
         end else begin
            cs_pin = 1'b1; tick(SYNC + 4);
            check("R9", "random stays i2c", i2c_sel, 1'b1);
         end
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule